// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that gives a host read and write access to a bank of eight 8-bit control registers. The registers themselves live outside the block. The block samples SCL and SDA with a fast system clock, synchronises and de-glitches both lines, and decodes START, repeated START and STOP. It answers one fixed 7-bit device address and acknowledges the bytes it accepts. For reads it pulls SDA low through an open-drain enable.

A register pointer selects the register to access. The host loads it with the first byte of a write. It advances by one after every data byte that is transferred, and it wraps from the last register back to the first. Because the pointer keeps its value between transactions, a read with no pointer byte continues from where the last access stopped.

On the register side the block issues a single-cycle write strobe with address and data. Read data comes back combinationally on the same address lines. That side has no valid/ready pair and no back-pressure: read data must be valid in the cycle the address is presented. A strobe is never held or retried.

Two plain control inputs come from the reset controller. One disables the bus path entirely. The other narrows writes to register 0 while a register reset is held.

Top module: `i2c_regbank_target`

## Requirements
- R1: The block responds to device address 7'b0001001, sent MSB first, followed by a direction bit (0 = write, 1 = read), and acknowledges a match. On any other address it sends no acknowledge and issues no strobe for any byte until the next START.
- R2: In a write, the first byte after the address loads the pointer from its low three bits, and its upper five bits are ignored. Every later byte is written to the register the pointer selects. The block acknowledges all of these bytes.
- R3: After register 7 the pointer moves on to register 0.
- R4: A read that starts straight after the address returns the register selected by the pointer left by the previous access, which is one past the last data byte transferred.
- R5: A combined read works as follows: a write of the address and a pointer byte, then a repeated START, then the read address. It returns registers in sequence from the new pointer.
- R6: After a read byte that the host acknowledges, the block drives the next byte MSB first. After a read byte that the host does not acknowledge, SDA is released and stays released.
- R7: A falling SDA while SCL is high starts a transfer, and a rising SDA while SCL is high ends it. A STOP keeps the pointer. The SDA pull changes only while the filtered SCL is low.
- R8: While `bus_enable` is low, SCL and SDA are ignored, SDA is not pulled, and the pointer is held at 0.
- R9: While `zero_only` is high, a data byte aimed at any register other than 0 produces no strobe. The byte is still acknowledged and the pointer still advances.
- R10: Each accepted write byte gives exactly one `reg_we` pulse, one cycle wide, with `reg_addr` on the target register. The pointer shows the next register in the following cycle.
- R11: A pulse of two system clocks or less on SCL or SDA has no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_enable | input | 1 | Low: bus inputs ignored, pointer cleared |
| zero_only | input | 1 | High: only register 0 may be written |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_addr | output | ADDR_W | Register pointer, used for both writes and reads |
| reg_wdata | output | 8 | Write data for the strobe |
| reg_rdata | input | 8 | Read data of the register at `reg_addr` |

## Verification
Two functions meet on the same wire. A STOP and a short spike on SDA while SCL is high look the same at the pins, so the de-glitch filter and the condition decoder must agree every time. The bench spikes SDA high for two clocks during every zero bit of a whole write transaction. The transfer passes only if every byte is still acknowledged and the register bank ends up exactly as computed. The second pair is the pointer advance on the final read byte and the host's NACK and STOP that end the transfer. This is judged by a following plain read that must return the register one past the last one read.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_ACK,
    PH_PTR,
    PH_PTR_ACK,
    PH_WDAT,
    PH_WDAT_ACK,
    PH_RDAT,
    PH_RACK
  } phase_t;
endpackage

// File: rtl/i2ct_filter.sv
// Synchroniser plus agreement window per line; output moves only when
// every sample in the window agrees.
module i2ct_filter #(
  parameter int LINES = 2,
  parameter int SYNC  = 2,
  parameter int LEN   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC-1:0] sync_q;
    logic [LEN-1:0]  win_q;
    logic            out_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '1;
        win_q  <= '1;
        out_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC-2:0], din[g]};
        win_q  <= {win_q[LEN-2:0], sync_q[SYNC-1]};
        if (&win_q)       out_q <= 1'b1;
        else if (~|win_q) out_q <= 1'b0;
      end
    end

    assign dout[g] = out_q;
  end
endmodule

// File: rtl/i2ct_cond.sv
// Bus event decoder on the filtered lines.
module i2ct_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start_o = scl & scl_q & sda_q & ~sda;
  assign stop_o  = scl & scl_q & ~sda_q & sda;
  assign rise_o  = scl & ~scl_q;
  assign fall_o  = ~scl & scl_q;
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2ct_pkg::*;
#(
  parameter int         ADDR_W      = 3,
  parameter logic [6:0] DEV_ADDR    = 7'h09,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_enable,
  input  logic              zero_only,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  logic [1:0] line_raw, line_clean;
  logic       scl_clean, sda_clean;
  logic       ev_start, ev_stop, ev_rise, ev_fall;

  // A disabled bus looks permanently idle to the decoder.
  assign line_raw = bus_enable ? {scl_i, sda_i} : 2'b11;

  i2ct_filter #(.LINES(2), .SYNC(SYNC_STAGES), .LEN(FILT_LEN)) u_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (line_raw),
    .dout (line_clean)
  );

  assign scl_clean = line_clean[1];
  assign sda_clean = line_clean[0];

  i2ct_cond u_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl    (scl_clean),
    .sda    (sda_clean),
    .start_o(ev_start),
    .stop_o (ev_stop),
    .rise_o (ev_rise),
    .fall_o (ev_fall)
  );

  phase_t              phase_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                full_q, rw_q, mack_q, pull_q, wpend_q;
  logic [BYTE_W-1:0]   shreg_q, tx_q, wdata_q;
  logic [ADDR_W-1:0]   ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
      wpend_q <= 1'b0;
      shreg_q <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      ptr_q   <= '0;
    end else if (!bus_enable) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      pull_q  <= 1'b0;
      wpend_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      // pointer advance in the cycle after a write strobe
      if (wpend_q) begin
        ptr_q   <= ptr_q + 1'b1;
        wpend_q <= 1'b0;
      end
      if (ev_start) begin
        phase_q <= PH_ADDR;
        cnt_q   <= '0;
        full_q  <= 1'b0;
        pull_q  <= 1'b0;
      end else if (ev_stop) begin
        phase_q <= PH_IDLE;
        pull_q  <= 1'b0;
      end else begin
        case (phase_q)
          PH_ADDR, PH_PTR, PH_WDAT: begin
            if (ev_rise) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_clean};
              if (cnt_q == CNT_W'(BYTE_W - 1)) full_q <= 1'b1;
              cnt_q <= cnt_q + 1'b1;
            end else if (ev_fall && full_q) begin
              full_q <= 1'b0;
              cnt_q  <= '0;
              if (phase_q == PH_ADDR) begin
                if (shreg_q[7:1] == DEV_ADDR) begin
                  rw_q    <= shreg_q[0];
                  pull_q  <= 1'b1;
                  phase_q <= PH_ADDR_ACK;
                end else begin
                  phase_q <= PH_IDLE;
                end
              end else if (phase_q == PH_PTR) begin
                ptr_q   <= shreg_q[ADDR_W-1:0];
                pull_q  <= 1'b1;
                phase_q <= PH_PTR_ACK;
              end else begin
                wdata_q <= shreg_q;
                wpend_q <= 1'b1;
                pull_q  <= 1'b1;
                phase_q <= PH_WDAT_ACK;
              end
            end
          end
          PH_ADDR_ACK: begin
            if (ev_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q    <= {reg_rdata[6:0], 1'b0};
                pull_q  <= ~reg_rdata[7];
                phase_q <= PH_RDAT;
              end else begin
                pull_q  <= 1'b0;
                phase_q <= PH_PTR;
              end
            end
          end
          PH_PTR_ACK, PH_WDAT_ACK: begin
            if (ev_fall) begin
              pull_q  <= 1'b0;
              phase_q <= PH_WDAT;
            end
          end
          PH_RDAT: begin
            if (ev_fall) begin
              if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                pull_q  <= 1'b0;
                ptr_q   <= ptr_q + 1'b1;
                cnt_q   <= '0;
                phase_q <= PH_RACK;
              end else begin
                pull_q <= ~tx_q[7];
                tx_q   <= {tx_q[6:0], 1'b0};
                cnt_q  <= cnt_q + 1'b1;
              end
            end
          end
          PH_RACK: begin
            if (ev_rise) begin
              mack_q <= ~sda_clean;
            end else if (ev_fall) begin
              if (mack_q) begin
                tx_q    <= {reg_rdata[6:0], 1'b0};
                pull_q  <= ~reg_rdata[7];
                phase_q <= PH_RDAT;
              end else begin
                phase_q <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull  = pull_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = wpend_q & (~zero_only | (ptr_q == '0));
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_enable,
  input logic              scl_clean,
  input logic              sda_pull,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr
);
  // R8
  pull_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_enable |=> !sda_pull);

  // R8
  ptr_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_enable |=> (reg_addr == '0));

  // R10
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R10
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && bus_enable) |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));

  // R7
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_clean && $past(scl_clean) && bus_enable && $past(bus_enable))
      |-> $stable(sda_pull));
endmodule

bind i2c_regbank_target i2ct_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_enable(bus_enable),
  .scl_clean (scl_clean),
  .sda_pull  (sda_pull),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr)
);

// File: tb/test_i2c_regbank_target.sv
`timescale 1ns/1ps
module test_i2c_regbank_target;
  localparam int Q = 15;
  localparam logic [6:0] DEV = 7'h09;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_enable = 1'b1;
  logic zero_only = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  wire  sda_line = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  i2c_regbank_target i_i2c_regbank_target (
    .clk(clk), .rst_n(rst_n), .bus_enable(bus_enable), .zero_only(zero_only),
    .scl_i(scl_m), .sda_i(sda_line), .sda_pull(sda_pull), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // register file on the bench side
  logic [7:0] bank [8];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) bank[k] <= 8'h00;
    end else if (reg_we) begin
      bank[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = bank[reg_addr];

  int we_cnt = 0;
  bit we_prev = 1'b0, we_wide = 1'b0;
  always_ff @(posedge clk) begin
    we_prev <= reg_we;
    if (reg_we) we_cnt <= we_cnt + 1;
    if (reg_we && we_prev) we_wide <= 1'b1;
  end

  int checks = 0, fails = 0;
  logic [7:0] exp_bank [8];
  logic [2:0] exp_ptr = 3'd0;
  bit glitch_en = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl_m) begin
      sda_m = 1'b1; wc(Q); scl_m = 1'b1; wc(2*Q);
    end
    sda_m = 1'b0; wc(2*Q); scl_m = 1'b0; wc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wc(Q); scl_m = 1'b1; wc(2*Q); sda_m = 1'b1; wc(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wc(Q); scl_m = 1'b1; wc(Q);
      if (glitch_en && !b[i]) begin
        sda_m = 1'b1; wc(2); sda_m = 1'b0; wc(Q-2);
      end else begin
        wc(Q);
      end
      scl_m = 1'b0; wc(Q);
    end
    sda_m = 1'b1; wc(Q); scl_m = 1'b1; wc(Q);
    ack = !sda_line;
    wc(Q); scl_m = 1'b0; wc(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wc(Q); scl_m = 1'b1; wc(Q); d[i] = sda_line; wc(Q); scl_m = 1'b0; wc(Q);
    end
    sda_m = !give_ack; wc(Q); scl_m = 1'b1; wc(2*Q); scl_m = 1'b0; sda_m = 1'b1; wc(Q);
  endtask

  task automatic cmp_bank(input string req);
    int bad, first;
    bad = 0; first = 0;
    for (int k = 0; k < 8; k++)
      if (bank[k] !== exp_bank[k]) begin
        if (bad == 0) first = k;
        bad++;
      end
    chk(bad == 0, req, int'(bank[first]), int'(exp_bank[first]));
  endtask

  task automatic do_write(input logic [2:0] p, input int n);
    bit a; logic [7:0] d; int we0, acc;
    we0 = we_cnt; acc = 0;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk(a, "R1 write address ack", a, 1);
    // R2: upper five pointer bits are ignored
    send_byte({5'($urandom), p}, a); chk(a, "R2 pointer byte ack", a, 1);
    exp_ptr = p;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, a); chk(a, "R2 data byte ack", a, 1);
      if (!zero_only || exp_ptr == 3'd0) begin
        exp_bank[exp_ptr] = d; acc++;
      end
      exp_ptr = exp_ptr + 3'd1;
    end
    bus_stop(); wc(4);
    chk(we_cnt - we0 == acc, "R10 one strobe per accepted byte", we_cnt - we0, acc);
    cmp_bank("R2 bank after write");
  endtask

  task automatic do_read(input bit comb, input logic [2:0] p, input int n);
    bit a; logic [7:0] d;
    bus_start();
    if (comb) begin
      send_byte({DEV, 1'b0}, a); chk(a, "R5 address ack", a, 1);
      send_byte({5'd0, p}, a);   chk(a, "R5 pointer ack", a, 1);
      exp_ptr = p;
      bus_start();
    end
    send_byte({DEV, 1'b1}, a); chk(a, "R1 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n-1, d);
      chk(d == exp_bank[exp_ptr], comb ? "R5 combined read data" : "R4 plain read data",
          int'(d), int'(exp_bank[exp_ptr]));
      exp_ptr = exp_ptr + 3'd1;
      if (k < n-1)
        chk(sda_line == exp_bank[exp_ptr][7], "R6 next byte driven after ACK",
            sda_line, exp_bank[exp_ptr][7]);
    end
    wc(Q);
    chk(!sda_pull, "R6 SDA released after NACK", sda_pull, 0);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    bit a; logic [7:0] d; int we0;
    void'($urandom(32'd4711));
    for (int k = 0; k < 8; k++) exp_bank[k] = 8'h00;
    wc(5); rst_n = 1'b1; wc(10);

    // reset state
    chk(!sda_pull, "R7 SDA idle after reset", sda_pull, 0);
    chk(!reg_we, "R10 no strobe after reset", reg_we, 0);
    chk(reg_addr == 3'd0, "R8 pointer zero after reset", reg_addr, 0);

    // R3: write across the top of the bank
    do_write(3'd6, 3);
    chk(reg_addr == 3'd1, "R3 pointer wrapped", reg_addr, 1);
    // R4: plain read continues after last access
    do_read(1'b0, 3'd0, 2);
    // R5 and R3: combined read wraps
    do_read(1'b1, 3'd7, 2);
    chk(!we_wide, "R10 strobe one cycle wide", we_wide, 0);

    // R1: wrong address
    we0 = we_cnt;
    bus_start();
    send_byte({7'h12, 1'b0}, a); chk(!a, "R1 no ack on wrong address", a, 0);
    send_byte(8'h00, a);          chk(!a, "R1 no ack after mismatch", a, 0);
    send_byte(8'h00, a);          chk(!a, "R1 no ack after mismatch", a, 0);
    bus_stop(); wc(4);
    chk(we_cnt == we0, "R1 no strobe after mismatch", we_cnt - we0, 0);
    cmp_bank("R1 bank untouched");

    // R7: STOP after pointer byte keeps the pointer
    bus_start();
    send_byte({DEV, 1'b0}, a); send_byte(8'h03, a);
    bus_stop(); exp_ptr = 3'd3;
    do_read(1'b0, 3'd0, 1);
    chk(reg_addr == 3'd4, "R7 pointer after STOP and read", reg_addr, 4);

    // R9: writes narrowed to register 0
    zero_only = 1'b1;
    do_write(3'd7, 3);
    chk(reg_addr == 3'd2, "R9 pointer still advances", reg_addr, 2);
    zero_only = 1'b0;

    // R8: bus disabled
    bus_enable = 1'b0; wc(4);
    chk(reg_addr == 3'd0, "R8 pointer cleared", reg_addr, 0);
    exp_ptr = 3'd0;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk(!a, "R8 no ack while disabled", a, 0);
    send_byte(8'h05, a);       chk(!sda_pull, "R8 SDA not pulled", sda_pull, 0);
    bus_stop();
    cmp_bank("R8 bank untouched");
    bus_enable = 1'b1; wc(20);

    // R11: spikes on SDA while SCL high
    glitch_en = 1'b1;
    do_write(3'd2, 3);
    glitch_en = 1'b0;
    cmp_bank("R11 bank after spiked write");

    // random mix
    for (int t = 0; t < 20; t++) begin
      int op, n;
      logic [2:0] p;
      op = int'($urandom % 3); n = 1 + int'($urandom % 4); p = 3'($urandom);
      if (op == 0)      do_write(p, n);
      else if (op == 1) do_read(1'b0, 3'd0, n);
      else              do_read(1'b1, p, n);
    end
    chk(!we_wide, "R10 strobe one cycle wide", we_wide, 0);

    done = 1'b1;
    finish_run();
  end
endmodule